// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block keeps one readiness bit for every physical register of a single unified register index space. Integer registers take the low indices and floating-point registers follow directly after the last integer index, so with 96 of each, indices 0 to 95 are integer and 96 to 191 are floating-point. A bit reads 1 when the register's value has been produced and 0 while a recorded producer for it is still outstanding.

Three things act on the scoreboard in each cycle. A producer record clears the bit of its destination, and the producing instruction does not have to be placed in the issue queue for this. A completion broadcast sets the bit of the completing instruction's destination. A readiness query looks up the source operands of one incoming instruction and reports whether all of its valid sources are ready, so that the instruction can go straight to the ready queues. A broadcast in the same cycle as a query counts as ready for that query. The dependency lists, renaming and register values are kept elsewhere.

Top module: `regwake_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, every register index from 0 to 191 reads ready.
- R2: A producer record (`prod_valid`) for an in-range index makes that register read not ready from the next cycle. Other registers are not affected.
- R3: A completion broadcast (`wake_valid`) for an in-range index makes that register read ready from the next cycle.
- R4: If a producer record and a broadcast name the same register in the same cycle, the register reads not ready afterwards.
- R5: A query source whose register is not ready reads ready in a cycle in which a broadcast names that same register.
- R6: `qry_ready` is 1 only while `qry_valid` is 1 and every source with its `qry_src_valid` bit set is ready. Sources whose valid bit is clear are ignored, so a query with no valid sources is ready. Source i uses bits [8i+7:8i] of `qry_src_idx`.
- R7: A producer record or broadcast with an index of 192 or higher raises `idx_err` in the same cycle and leaves every readiness bit unchanged.
- R8: A valid query source with an index of 192 or higher raises `idx_err` in the same cycle and reads not ready, which forces `qry_ready` to 0.
- R9: `qry_src_fp[i]` is 1 exactly when source i has an index from 96 to 191.
- R10: A producer record in the same cycle as a query does not change that query's answer. It takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_valid | input | 1 | Record a producer for `prod_idx` |
| prod_idx | input | 8 | Destination register of the recorded producer |
| wake_valid | input | 1 | Completion broadcast for `wake_idx` |
| wake_idx | input | 8 | Destination register of the completing producer |
| qry_valid | input | 1 | A readiness query is presented |
| qry_src_valid | input | 2 | Per-source valid bits of the query |
| qry_src_idx | input | 16 | Source register indices, source i in bits [8i+7:8i] |
| qry_src_rdy | output | 2 | Source i is valid and ready |
| qry_src_fp | output | 2 | Source i lies in the floating-point range |
| qry_ready | output | 1 | All valid sources of the query are ready |
| idx_err | output | 1 | Some index in use this cycle is out of range |

## Verification
The assertions take the three input channels as independent of each other. For one exception they rely on a caller that never sends a producer record and a broadcast for the same register unless it intends the producer to win: the check that a broadcast sets its bit excludes the cycles where the two collide. The stable-map check for an out-of-range producer record only covers cycles without a broadcast. For this reason the directed stimulus drives at most one channel per cycle, except in the scenarios that test collisions, bypass and out-of-range handling on purpose. Every expected value follows from a short history of records and broadcasts that the bench keeps track of itself.

// File: rtl/sb_pkg.sv
// Package: default sizing shared by the scoreboard and its checker.
// Assumes the integer registers take the low indices of the unified space.
package sb_pkg;
    localparam int SB_DEF_INT_REGS = 96;
    localparam int SB_DEF_FP_REGS  = 96;
    localparam int SB_DEF_NUM_SRC  = 2;
endpackage

// File: rtl/sb_idx_check.sv
// Module: classifies one register index of the unified space.
// Assumes IDX_W can hold TOTAL itself, so out-of-range values are representable.
module sb_idx_check #(
    parameter int TOTAL    = 192,
    parameter int INT_REGS = 96,
    parameter int IDX_W    = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic             in_range,
    output logic             is_fp
);
    localparam logic [IDX_W-1:0] LIMIT  = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] FP_LOW = IDX_W'(INT_REGS);

    // Range and register-class decode.
    always_comb begin
        in_range = (idx < LIMIT);
        is_fp    = in_range && (idx >= FP_LOW);
    end
endmodule

// File: rtl/sb_ready_array.sv
// Module: one ready flop per register; a clear beats a set on the same bit.
// Assumes clr_en/set_en are asserted only for in-range indices.
module sb_ready_array #(
    parameter int TOTAL = 192,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [TOTAL-1:0] ready_map
);
    for (genvar g = 0; g < TOTAL; g++) begin : g_bit
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic clr_hit;
        logic set_hit;

        // Decode whether this register is named by either update.
        always_comb begin
            clr_hit = clr_en && (clr_idx == MY_IDX);
            set_hit = set_en && (set_idx == MY_IDX);
        end

        // Ready flop: reset to ready, producer record wins over wakeup.
        always_ff @(posedge clk) begin
            if (!rst_n)       ready_map[g] <= 1'b1;
            else if (clr_hit) ready_map[g] <= 1'b0;
            else if (set_hit) ready_map[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/sb_src_lookup.sv
// Module: readiness of one query source, with same-cycle wakeup bypass.
// Assumes wake_en is already qualified by the wakeup index range check.
module sb_src_lookup #(
    parameter int TOTAL    = 192,
    parameter int INT_REGS = 96,
    parameter int IDX_W    = 8
) (
    input  logic [TOTAL-1:0] ready_map,
    input  logic             src_valid,
    input  logic [IDX_W-1:0] src_idx,
    input  logic             wake_en,
    input  logic [IDX_W-1:0] wake_idx,
    output logic             src_ok,
    output logic             src_rdy,
    output logic             src_fp,
    output logic             src_bad
);
    logic in_range;
    logic is_fp;
    logic stored;

    sb_idx_check #(.TOTAL(TOTAL), .INT_REGS(INT_REGS), .IDX_W(IDX_W)) u_chk (
        .idx      (src_idx),
        .in_range (in_range),
        .is_fp    (is_fp)
    );

    // Look up the stored bit and merge a matching broadcast.
    always_comb begin
        stored  = in_range ? ready_map[src_idx] : 1'b0;
        src_rdy = src_valid && in_range && (stored || (wake_en && wake_idx == src_idx));
        src_ok  = !src_valid || src_rdy;
        src_fp  = is_fp;
        src_bad = src_valid && !in_range;
    end
endmodule

// File: rtl/regwake_scoreboard.sv
// Module: secondary wakeup scoreboard over the unified integer+FP index space.
// Producer records clear, completion broadcasts set, queries read with bypass.
// Assumes one producer record, one broadcast and one query per cycle at most.
module regwake_scoreboard
    import sb_pkg::*;
#(
    parameter int INT_REGS = SB_DEF_INT_REGS,
    parameter int FP_REGS  = SB_DEF_FP_REGS,
    parameter int NUM_SRC  = SB_DEF_NUM_SRC,
    localparam int TOTAL   = INT_REGS + FP_REGS,
    localparam int IDX_W   = $clog2(TOTAL + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prod_valid,
    input  logic [IDX_W-1:0]         prod_idx,
    input  logic                     wake_valid,
    input  logic [IDX_W-1:0]         wake_idx,
    input  logic                     qry_valid,
    input  logic [NUM_SRC-1:0]       qry_src_valid,
    input  logic [NUM_SRC*IDX_W-1:0] qry_src_idx,
    output logic [NUM_SRC-1:0]       qry_src_rdy,
    output logic [NUM_SRC-1:0]       qry_src_fp,
    output logic                     qry_ready,
    output logic                     idx_err
);
    logic [TOTAL-1:0]   ready_map;
    logic               prod_in, wake_in;
    logic               prod_fp_unused, wake_fp_unused;
    logic               prod_en, wake_en;
    logic [NUM_SRC-1:0] src_ok, src_bad;

    sb_idx_check #(.TOTAL(TOTAL), .INT_REGS(INT_REGS), .IDX_W(IDX_W)) u_prod_chk (
        .idx (prod_idx), .in_range (prod_in), .is_fp (prod_fp_unused)
    );
    sb_idx_check #(.TOTAL(TOTAL), .INT_REGS(INT_REGS), .IDX_W(IDX_W)) u_wake_chk (
        .idx (wake_idx), .in_range (wake_in), .is_fp (wake_fp_unused)
    );

    // Qualify updates: out-of-range indices never reach the array.
    always_comb begin
        prod_en = prod_valid && prod_in;
        wake_en = wake_valid && wake_in;
    end

    sb_ready_array #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (prod_en),
        .clr_idx   (prod_idx),
        .set_en    (wake_en),
        .set_idx   (wake_idx),
        .ready_map (ready_map)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sb_src_lookup #(.TOTAL(TOTAL), .INT_REGS(INT_REGS), .IDX_W(IDX_W)) u_lk (
            .ready_map (ready_map),
            .src_valid (qry_valid && qry_src_valid[s]),
            .src_idx   (qry_src_idx[s*IDX_W +: IDX_W]),
            .wake_en   (wake_en),
            .wake_idx  (wake_idx),
            .src_ok    (src_ok[s]),
            .src_rdy   (qry_src_rdy[s]),
            .src_fp    (qry_src_fp[s]),
            .src_bad   (src_bad[s])
        );
    end

    // Combine per-source answers and the range errors of all channels.
    always_comb begin
        qry_ready = qry_valid && (&src_ok);
        idx_err   = (prod_valid && !prod_in) || (wake_valid && !wake_in) || (|src_bad);
    end
endmodule

// File: rtl/regwake_scoreboard_chk.sv
// Module: property checker for regwake_scoreboard, attached by bind below.
// Assumes it observes the top's ports and its internal ready_map.
module regwake_scoreboard_chk #(
    parameter int INT_REGS = 96,
    parameter int FP_REGS  = 96,
    parameter int NUM_SRC  = 2,
    localparam int TOTAL   = INT_REGS + FP_REGS,
    localparam int IDX_W   = $clog2(TOTAL + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     prod_valid,
    input logic [IDX_W-1:0]         prod_idx,
    input logic                     wake_valid,
    input logic [IDX_W-1:0]         wake_idx,
    input logic                     qry_valid,
    input logic [NUM_SRC-1:0]       qry_src_valid,
    input logic [NUM_SRC*IDX_W-1:0] qry_src_idx,
    input logic                     qry_ready,
    input logic                     idx_err,
    input logic [TOTAL-1:0]         ready_map
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(TOTAL);

    assert_reset_all_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&ready_map));

    assert_record_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_idx < LIMIT) |=> !ready_map[$past(prod_idx)]);

    assert_wake_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid && wake_idx < LIMIT && !(prod_valid && prod_idx == wake_idx))
        |=> ready_map[$past(wake_idx)]);

    assert_ready_needs_query_R6: assert property (@(posedge clk) disable iff (!rst_n)
        qry_ready |-> qry_valid);

    assert_bad_record_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_idx >= LIMIT) |-> idx_err);

    assert_bad_record_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_idx >= LIMIT && !wake_valid) |=> $stable(ready_map));

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assert_bad_source_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (qry_valid && qry_src_valid[s] && qry_src_idx[s*IDX_W +: IDX_W] >= LIMIT)
            |-> (!qry_ready && idx_err));
    end
endmodule

bind regwake_scoreboard regwake_scoreboard_chk #(
    .INT_REGS (INT_REGS),
    .FP_REGS  (FP_REGS),
    .NUM_SRC  (NUM_SRC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prod_valid    (prod_valid),
    .prod_idx      (prod_idx),
    .wake_valid    (wake_valid),
    .wake_idx      (wake_idx),
    .qry_valid     (qry_valid),
    .qry_src_valid (qry_src_valid),
    .qry_src_idx   (qry_src_idx),
    .qry_ready     (qry_ready),
    .idx_err       (idx_err),
    .ready_map     (ready_map)
);

// File: tb/sim_regwake_scoreboard.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_regwake_scoreboard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prod_valid, wake_valid, qry_valid;
    logic [7:0]  prod_idx, wake_idx;
    logic [1:0]  qry_src_valid;
    logic [15:0] qry_src_idx;
    logic [1:0]  qry_src_rdy, qry_src_fp;
    logic        qry_ready, idx_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    regwake_scoreboard u0 (
        .clk (clk), .rst_n (rst_n),
        .prod_valid (prod_valid), .prod_idx (prod_idx),
        .wake_valid (wake_valid), .wake_idx (wake_idx),
        .qry_valid (qry_valid), .qry_src_valid (qry_src_valid),
        .qry_src_idx (qry_src_idx), .qry_src_rdy (qry_src_rdy),
        .qry_src_fp (qry_src_fp), .qry_ready (qry_ready), .idx_err (idx_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        prod_valid = 0; prod_idx = 0; wake_valid = 0; wake_idx = 0;
        qry_valid = 0; qry_src_valid = 0; qry_src_idx = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    // Query one register alone; returns readiness sampled mid-cycle.
    task automatic probe(input logic [7:0] r, output logic rdy);
        idle();
        qry_valid = 1; qry_src_valid = 2'b01; qry_src_idx = {8'd0, r};
        @(negedge clk);
        rdy = qry_ready;
        tick();
    endtask

    task automatic record(input logic [7:0] r);
        idle(); prod_valid = 1; prod_idx = r; tick();
    endtask

    task automatic wake(input logic [7:0] r);
        idle(); wake_valid = 1; wake_idx = r; tick();
    endtask

    task automatic t_reset();
        logic rdy;
        foreach (u0.qry_src_fp[k]) begin end
        probe(8'd0, rdy);   check("R1 idx0", rdy, 1);
        probe(8'd95, rdy);  check("R1 idx95", rdy, 1);
        probe(8'd96, rdy);  check("R1 idx96", rdy, 1);
        probe(8'd191, rdy); check("R1 idx191", rdy, 1);
        check("R1 no err", idx_err, 0);
    endtask

    task automatic t_clear_set();
        logic rdy;
        record(8'd10);
        probe(8'd10, rdy); check("R2 cleared", rdy, 0);
        probe(8'd11, rdy); check("R2 neighbour", rdy, 1);
        probe(8'd10, rdy); check("R2 holds", rdy, 0);
        wake(8'd10);
        probe(8'd10, rdy); check("R3 set", rdy, 1);
    endtask

    task automatic t_collision();
        logic rdy;
        idle(); prod_valid = 1; prod_idx = 8'd150; wake_valid = 1; wake_idx = 8'd150; tick();
        probe(8'd150, rdy); check("R4 producer wins", rdy, 0);
        wake(8'd150);
        probe(8'd150, rdy); check("R3 later wake", rdy, 1);
    endtask

    task automatic t_bypass();
        logic rdy;
        record(8'd20);
        probe(8'd20, rdy); check("R5 not ready before", rdy, 0);
        idle(); qry_valid = 1; qry_src_valid = 2'b10; qry_src_idx = {8'd20, 8'd0};
        wake_valid = 1; wake_idx = 8'd20;
        @(negedge clk);
        check("R5 bypass ready", qry_ready, 1);
        check("R5 bypass src", qry_src_rdy, 2'b10);
        tick();
    endtask

    task automatic t_multi();
        record(8'd30);
        idle(); qry_valid = 1; qry_src_valid = 2'b11; qry_src_idx = {8'd31, 8'd30};
        @(negedge clk);
        check("R6 one not ready", qry_ready, 0);
        check("R6 src rdy", qry_src_rdy, 2'b10);
        qry_src_valid = 2'b10;
        @(posedge clk); #1; @(negedge clk);
        check("R6 invalid ignored", qry_ready, 1);
        qry_src_valid = 2'b00;
        @(posedge clk); #1; @(negedge clk);
        check("R6 no sources", qry_ready, 1);
        qry_valid = 0; qry_src_valid = 2'b11; qry_src_idx = {8'd31, 8'd31};
        @(posedge clk); #1; @(negedge clk);
        check("R6 no query", qry_ready, 0);
        tick();
        wake(8'd30);
    endtask

    task automatic t_range();
        logic rdy;
        idle(); prod_valid = 1; prod_idx = 8'd200;
        @(negedge clk); check("R7 prod err", idx_err, 1);
        tick();
        probe(8'd8, rdy);   check("R7 idx8 kept", rdy, 1);
        probe(8'd72, rdy);  check("R7 idx72 kept", rdy, 1);
        probe(8'd191, rdy); check("R7 idx191 kept", rdy, 1);
        record(8'd40);
        idle(); wake_valid = 1; wake_idx = 8'd255;
        @(negedge clk); check("R7 wake err", idx_err, 1);
        tick();
        probe(8'd40, rdy); check("R7 bad wake ignored", rdy, 0);
        wake(8'd40);
    endtask

    task automatic t_qrange();
        idle(); qry_valid = 1; qry_src_valid = 2'b01; qry_src_idx = {8'd0, 8'd192};
        @(negedge clk);
        check("R8 err", idx_err, 1);
        check("R8 not ready", qry_ready, 0);
        check("R8 src", qry_src_rdy, 2'b00);
        tick();
    endtask

    task automatic t_class();
        idle(); qry_valid = 1; qry_src_valid = 2'b11; qry_src_idx = {8'd96, 8'd95};
        @(negedge clk); check("R9 95/96", qry_src_fp, 2'b10);
        qry_src_idx = {8'd0, 8'd191};
        @(posedge clk); #1; @(negedge clk);
        check("R9 191/0", qry_src_fp, 2'b01);
        tick();
    endtask

    task automatic t_same_cycle_record();
        logic rdy;
        idle(); qry_valid = 1; qry_src_valid = 2'b01; qry_src_idx = {8'd0, 8'd50};
        prod_valid = 1; prod_idx = 8'd50;
        @(negedge clk); check("R10 query unaffected", qry_ready, 1);
        tick();
        probe(8'd50, rdy); check("R10 later cleared", rdy, 0);
        wake(8'd50);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_clear_set();
        t_collision();
        t_bypass();
        t_multi();
        t_range();
        t_qrange();
        t_class();
        t_same_cycle_record();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule